// File: doc/BRIEF.md
# Indexed Port Packet Memory Access

This block gives a host two narrow windows onto a packet memory: an index port and a 16-bit data port. The host first writes a register number to the index port. Later data-port accesses then reach that register. Two byte-addressed pointers, one for reading and one for writing, locate words in a 16 KiB shared memory. Four command indexes move one 16-bit word per access through the data port. Two of them advance their pointer by two bytes after the access, and the other two leave it where it is.

An auto-wrap enable, bit 7 of a mask register, keeps the pointers inside fixed regions. With the enable set, the write pointer folds back into the low region below 0x0C00. The read pointer is lifted into the region from 0x0C00 up to the top of memory. Turning the enable on also moves the read pointer's high byte to 0x0C.

The memory sits outside the block, behind a request/grant hook, so that transmit and receive engines can share it. The memory returns read data in the same cycle as the request. A data access that needs the memory waits, with `bus_ready` low, until the grant arrives.

Top module: `ipm_host_port`

## Requirements
- R1: A host write to the index port (`bus_data_sel`=0) stores `bus_wdata[7:0]` as the current index. A host read of the index port returns that index in bits 7:0, with bits 15:8 zero.
- R2: A data-port read at index 0xF0 or 0xF2 returns a little-endian word from memory: bits 7:0 are the byte at the read pointer and bits 15:8 the byte at the read pointer + 1. `mem_addr` carries the low 14 bits of the pointer, and the memory places the byte at `mem_addr` in `mem_rdata[7:0]` and the next byte in `mem_rdata[15:8]`.
- R3: A data-port read at index 0xF2 advances the read pointer by 2. A read at index 0xF0 leaves it unchanged.
- R4: A data-port write at index 0xF8 or 0xF6 presents `bus_wdata` to memory at the low 14 bits of the write pointer, with `mem_we` set. Index 0xF8 then advances the write pointer by 2, and index 0xF6 leaves it unchanged.
- R5: With mask bit 7 set, 0x0C00 is subtracted once from an advanced write pointer that is at or above 0x0C00. With the bit clear, the write pointer advances modulo 2^16.
- R6: An advanced read pointer (16 bits, modulo 2^16) has 0x4000 subtracted once if it is at or above 0x4000. With mask bit 7 set, a result below 0x0C00 then has 0x0C00 added.
- R7: A mask write that changes bit 7 from 0 to 1 sets the read pointer's high byte to 0x0C and keeps its low byte. A mask write that leaves bit 7 at 1 does not touch the read pointer.
- R8: The read pointer bytes are at indexes 0xF4 (low) and 0xF5 (high), the write pointer bytes at 0xFA (low) and 0xFB (high), and the 8-bit mask at 0xFF. All are read and written through the data port using bits 7:0, and writing one byte leaves the other byte unchanged.
- R9: A data-port read at any other index returns 0, and so does a read at 0xF6 or 0xF8. A data-port write at any other index, including 0xF0 and 0xF2, changes no pointer, no mask and no memory.
- R10: While a memory command is requested and `mem_gnt` is low, `bus_ready` stays low and no pointer moves. Each command takes effect once, in the cycle it is granted.
- R11: After reset, the index, both pointers and the mask read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_data_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid while `bus_valid` and `bus_ready` are high |
| bus_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Byte address of the low byte |
| mem_wdata | output | 16 | Memory write word, little-endian |
| mem_rdata | input | 16 | Memory read word, returned combinationally |
| mem_gnt | input | 1 | Arbitration grant |

## Verification
Two things can happen to a pointer in the same cycle: the advance by two and the wrap correction. Both feed one next-state value. The bench sweeps the read pointer and the write pointer across every region, with auto-wrap both off and on, and includes the values just below 0x0C00, just below 0x4000 and at the top of the 16-bit range. It issues one advancing command at each value and reads both pointer bytes back. The result must match the arithmetic model in the bench, which proves the two effects combine and that the correction is applied exactly once. A stalled grant tests the second overlap, a pending command against a pointer update. The bench holds `mem_gnt` low for several cycles, then checks that the advance is applied once after the grant.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  localparam logic [7:0] IDX_PEEK   = 8'hF0;
  localparam logic [7:0] IDX_RDADV  = 8'hF2;
  localparam logic [7:0] IDX_RP_LO  = 8'hF4;
  localparam logic [7:0] IDX_RP_HI  = 8'hF5;
  localparam logic [7:0] IDX_WRSTAY = 8'hF6;
  localparam logic [7:0] IDX_WRADV  = 8'hF8;
  localparam logic [7:0] IDX_WP_LO  = 8'hFA;
  localparam logic [7:0] IDX_WP_HI  = 8'hFB;
  localparam logic [7:0] IDX_MASK   = 8'hFF;

  typedef enum logic [3:0] {
    OP_NONE, OP_PEEK, OP_RDADV, OP_WRSTAY, OP_WRADV,
    OP_RPLO, OP_RPHI, OP_WPLO, OP_WPHI, OP_MASK
  } ipm_op_e;
endpackage

// File: rtl/ipm_index_decode.sv
module ipm_index_decode
  import ipm_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  output logic [IDX_W-1:0] idx_q,
  output ipm_op_e          op
);
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    idx_nxt = idx_q;
    if (idx_we) idx_nxt = idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_nxt;
  end

  always_comb begin
    case (idx_q)
      IDX_PEEK:   op = OP_PEEK;
      IDX_RDADV:  op = OP_RDADV;
      IDX_WRSTAY: op = OP_WRSTAY;
      IDX_WRADV:  op = OP_WRADV;
      IDX_RP_LO:  op = OP_RPLO;
      IDX_RP_HI:  op = OP_RPHI;
      IDX_WP_LO:  op = OP_WPLO;
      IDX_WP_HI:  op = OP_WPHI;
      IDX_MASK:   op = OP_MASK;
      default:    op = OP_NONE;
    endcase
  end

  // R1
  idx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> idx_q == $past(idx_wdata));
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));
endmodule

// File: rtl/ipm_ptr.sv
module ipm_ptr #(
  parameter int          PTR_W     = 16,
  parameter int unsigned BASE      = 32'h0C00,
  parameter int unsigned SPAN      = 32'h4000,
  parameter bit          READ_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       ld_val,
  input  logic             adv,
  input  logic             wrap_en,
  input  logic             force_hi,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int               HI_W   = PTR_W - 8;
  localparam logic [PTR_W-1:0] BASE_V = PTR_W'(BASE);
  localparam logic [PTR_W-1:0] SPAN_V = PTR_W'(SPAN);
  localparam logic [PTR_W-1:0] STEP   = PTR_W'(2);

  logic [PTR_W-1:0] sum;
  logic [PTR_W-1:0] adv_val;
  logic [PTR_W-1:0] ptr_nxt;
  logic             ptr_en;

  assign sum = ptr_q + STEP;

  if (READ_SIDE) begin : g_rd
    logic [PTR_W-1:0] folded;
    assign folded  = (sum >= SPAN_V) ? sum - SPAN_V : sum;
    assign adv_val = (wrap_en && folded < BASE_V) ? folded + BASE_V : folded;

    // R6
    rd_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv && wrap_en && !ld_lo && !ld_hi && !force_hi && ptr_q < SPAN_V
      |=> ptr_q >= BASE_V && ptr_q < SPAN_V);
  end else begin : g_wr
    assign adv_val = (wrap_en && sum >= BASE_V) ? sum - BASE_V : sum;

    // R5
    wr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv && wrap_en && !ld_lo && !ld_hi && ptr_q < BASE_V
      |=> ptr_q < BASE_V);
  end

  assign ptr_en = ld_lo | ld_hi | force_hi | adv;

  always_comb begin
    ptr_nxt = ptr_q;
    if (ld_lo)         ptr_nxt[7:0]       = ld_val;
    else if (ld_hi)    ptr_nxt[PTR_W-1:8] = ld_val[HI_W-1:0];
    else if (force_hi) ptr_nxt[PTR_W-1:8] = BASE_V[PTR_W-1:8];
    else if (adv)      ptr_nxt            = adv_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  // R10
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_en |=> $stable(ptr_q));
  // R8
  lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8]));
endmodule

// File: rtl/ipm_host_port.sv
module ipm_host_port
  import ipm_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          MEM_AW    = 14,
  parameter int          PTR_W     = 16,
  parameter int unsigned WRAP_BASE = 32'h0C00,
  parameter int          AW_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_data_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_gnt
);
  localparam int unsigned MEM_SPAN = 32'd1 << MEM_AW;
  localparam int          REG_W    = 8;
  localparam logic [PTR_W-1:0] BASE_V = PTR_W'(WRAP_BASE);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [REG_W-1:0] idx_q;
  ipm_op_e          op;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [REG_W-1:0] mask_q, mask_nxt;
  logic             rd_cmd, wr_cmd, fire, data_wr, data_rd, idx_we;
  logic             mask_wr, aw_on, force_hi;

  assign rd_cmd  = !bus_write && (op == OP_PEEK || op == OP_RDADV);
  assign wr_cmd  =  bus_write && (op == OP_WRSTAY || op == OP_WRADV);
  assign mem_req = bus_valid && bus_data_sel && (rd_cmd || wr_cmd);
  assign mem_we  = mem_req && bus_write;
  assign mem_addr  = wr_cmd ? wr_ptr[MEM_AW-1:0] : rd_ptr[MEM_AW-1:0];
  assign mem_wdata = bus_wdata;
  assign bus_ready = mem_req ? mem_gnt : 1'b1;

  assign fire    = bus_valid && bus_ready;
  assign data_wr = fire && bus_data_sel && bus_write;
  assign data_rd = fire && bus_data_sel && !bus_write;
  assign idx_we  = fire && !bus_data_sel && bus_write;
  assign mask_wr = data_wr && (op == OP_MASK);
  assign aw_on   = mask_q[AW_BIT];
  assign force_hi = mask_wr && !aw_on && bus_wdata[AW_BIT];

  ipm_index_decode #(.IDX_W(REG_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync),
    .idx_we    (idx_we),
    .idx_wdata (bus_wdata[REG_W-1:0]),
    .idx_q     (idx_q),
    .op        (op)
  );

  ipm_ptr #(.PTR_W(PTR_W), .BASE(WRAP_BASE), .SPAN(MEM_SPAN), .READ_SIDE(1'b1)) u_rd_ptr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .ld_lo    (data_wr && op == OP_RPLO),
    .ld_hi    (data_wr && op == OP_RPHI),
    .ld_val   (bus_wdata[7:0]),
    .adv      (data_rd && op == OP_RDADV),
    .wrap_en  (aw_on),
    .force_hi (force_hi),
    .ptr_q    (rd_ptr)
  );

  ipm_ptr #(.PTR_W(PTR_W), .BASE(WRAP_BASE), .SPAN(MEM_SPAN), .READ_SIDE(1'b0)) u_wr_ptr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .ld_lo    (data_wr && op == OP_WPLO),
    .ld_hi    (data_wr && op == OP_WPHI),
    .ld_val   (bus_wdata[7:0]),
    .adv      (data_wr && op == OP_WRADV),
    .wrap_en  (aw_on),
    .force_hi (1'b0),
    .ptr_q    (wr_ptr)
  );

  always_comb begin
    mask_nxt = mask_q;
    if (mask_wr) mask_nxt = bus_wdata[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)    mask_q <= '0;
    else if (mask_wr) mask_q <= mask_nxt;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_data_sel) begin
      bus_rdata[REG_W-1:0] = idx_q;
    end else begin
      case (op)
        OP_PEEK, OP_RDADV: bus_rdata = mem_rdata;
        OP_RPLO: bus_rdata[7:0] = rd_ptr[7:0];
        OP_RPHI: bus_rdata[7:0] = rd_ptr[PTR_W-1:8];
        OP_WPLO: bus_rdata[7:0] = wr_ptr[7:0];
        OP_WPHI: bus_rdata[7:0] = wr_ptr[PTR_W-1:8];
        OP_MASK: bus_rdata[REG_W-1:0] = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    mem_req && !mem_gnt |-> !bus_ready);
  // R3
  peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    data_rd && op == OP_PEEK |=> $stable(rd_ptr));
  // R4
  wr_stay_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    data_wr && op == OP_WRSTAY |=> $stable(wr_ptr));
  // R7
  force_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    force_hi |=> rd_ptr[PTR_W-1:8] == BASE_V[PTR_W-1:8]
                 && rd_ptr[7:0] == $past(rd_ptr[7:0]));
  // R9
  unmapped_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    data_wr && op == OP_NONE |=> $stable(rd_ptr) && $stable(wr_ptr) && $stable(mask_q));
  // R4
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    mem_we |-> mem_req && bus_data_sel);
endmodule

// File: tb/ipm_host_port_tb.sv
`timescale 1ns/1ps
module ipm_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, bus_data_sel;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        mem_req, mem_we, mem_gnt;
  logic [13:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int wlog_n = 0;
  logic [13:0] wlog_a;
  logic [15:0] wlog_d;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [13:0] a);
    pat = a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  function automatic logic [15:0] word_at(input logic [15:0] p);
    logic [13:0] a;
    a = p[13:0];
    word_at = {pat(a + 14'd1), pat(a)};
  endfunction

  assign mem_rdata = {pat(mem_addr + 14'd1), pat(mem_addr)};

  ipm_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_data_sel(bus_data_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  function automatic logic [15:0] rd_adv(input logic [15:0] p, input bit aw);
    logic [15:0] s;
    s = p + 16'd2;
    if (s >= 16'h4000) s = s - 16'h4000;
    if (aw && s < 16'h0C00) s = s + 16'h0C00;
    rd_adv = s;
  endfunction

  function automatic logic [15:0] wr_adv(input logic [15:0] p, input bit aw);
    logic [15:0] s;
    s = p + 16'd2;
    if (aw && s >= 16'h0C00) s = s - 16'h0C00;
    wr_adv = s;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic sel, input logic wr, input logic [15:0] d,
                      output logic [15:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_data_sel = sel; bus_wdata = d;
    #0.5;
    while (!bus_ready) begin @(negedge clk); #0.5; end
    q = bus_rdata;
    if (mem_req && mem_we) begin wlog_n++; wlog_a = mem_addr; wlog_d = mem_wdata; end
    @(posedge clk); #0.5;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [15:0] v);
    logic [15:0] q;
    xfer(1'b0, 1'b1, {8'h00, idx}, q);
    xfer(1'b1, 1'b1, v, q);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [15:0] v);
    logic [15:0] q;
    xfer(1'b0, 1'b1, {8'h00, idx}, q);
    xfer(1'b1, 1'b0, 16'h0, v);
  endtask

  task automatic get_ptr(input bit rd_side, output logic [15:0] p);
    logic [15:0] lo, hi;
    rd_reg(rd_side ? 8'hF4 : 8'hFA, lo);
    rd_reg(rd_side ? 8'hF5 : 8'hFB, hi);
    p = {hi[7:0], lo[7:0]};
  endtask

  task automatic set_ptr(input bit rd_side, input logic [15:0] p);
    wr_reg(rd_side ? 8'hF4 : 8'hFA, {8'h00, p[7:0]});
    wr_reg(rd_side ? 8'hF5 : 8'hFB, {8'h00, p[15:8]});
  endtask

  task automatic rd_case(input logic [15:0] p, input bit aw);
    logic [15:0] q, pp;
    set_ptr(1'b1, p);
    rd_reg(8'hF0, q);
    check("R2 peek data", q, word_at(p));
    get_ptr(1'b1, pp);
    check("R3 peek keeps pointer", pp, p);
    rd_reg(8'hF2, q);
    check("R2 advancing read data", q, word_at(p));
    get_ptr(1'b1, pp);
    check(aw ? "R6 read advance wrapped" : "R3 R6 read advance", pp, rd_adv(p, aw));
  endtask

  task automatic wr_case(input logic [15:0] p, input bit aw, input logic [15:0] d);
    logic [15:0] pp;
    int n0;
    set_ptr(1'b0, p);
    n0 = wlog_n;
    wr_reg(8'hF6, d);
    check("R4 stay write count", 16'(wlog_n - n0), 16'd1);
    check("R4 stay write addr", {2'b00, wlog_a}, {2'b00, p[13:0]});
    check("R4 stay write data", wlog_d, d);
    get_ptr(1'b0, pp);
    check("R4 stay keeps pointer", pp, p);
    wr_reg(8'hF8, ~d);
    check("R4 advancing write addr", {2'b00, wlog_a}, {2'b00, p[13:0]});
    check("R4 advancing write data", wlog_d, ~d);
    get_ptr(1'b0, pp);
    check(aw ? "R5 write advance wrapped" : "R4 R5 write advance", pp, wr_adv(p, aw));
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] q, p, m;
    bus_valid = 0; bus_write = 0; bus_data_sel = 0; bus_wdata = 0; mem_gnt = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11 reset state
    xfer(1'b0, 1'b0, 16'h0, q);
    check("R11 index after reset", q, 16'h0000);
    xfer(1'b1, 1'b0, 16'h0, q);
    check("R11 data at index 0 reads 0", q, 16'h0000);
    get_ptr(1'b1, p); check("R11 read pointer reset", p, 16'h0000);
    get_ptr(1'b0, p); check("R11 write pointer reset", p, 16'h0000);
    rd_reg(8'hFF, q); check("R11 mask reset", q, 16'h0000);

    // R1 index sweep
    for (int i = 0; i < 256; i += 17) begin
      xfer(1'b0, 1'b1, {8'hA5, 8'(i)}, q);
      xfer(1'b0, 1'b0, 16'h0, q);
      check("R1 index readback", q, {8'h00, 8'(i)});
    end

    // R8 byte-wise pointer access
    set_ptr(1'b1, 16'h3A5C);
    get_ptr(1'b1, p); check("R8 read pointer bytes", p, 16'h3A5C);
    wr_reg(8'hF4, 16'hFF11);
    get_ptr(1'b1, p); check("R8 low byte only", p, 16'h3A11);
    wr_reg(8'hF5, 16'h0022);
    get_ptr(1'b1, p); check("R8 high byte only", p, 16'h2211);
    set_ptr(1'b0, 16'hC3E7);
    get_ptr(1'b0, p); check("R8 write pointer bytes", p, 16'hC3E7);
    wr_reg(8'hFB, 16'h0077);
    get_ptr(1'b0, p); check("R8 write high byte only", p, 16'h77E7);
    wr_reg(8'hFF, 16'h0041);
    rd_reg(8'hFF, q); check("R8 mask readback", q, 16'h0041);

    // R2 R3 R6 read sweep, auto-wrap off then on
    for (int aw = 0; aw < 2; aw++) begin
      wr_reg(8'hFF, aw ? 16'h0080 : 16'h0000);
      for (int v = 0; v < 16'h4200; v += 16'h10E) rd_case(16'(v), aw[0]);
      rd_case(16'h0BFE, aw[0]);
      rd_case(16'h0BFF, aw[0]);
      rd_case(16'h3FFE, aw[0]);
      rd_case(16'h3FFF, aw[0]);
      rd_case(16'hFFFE, aw[0]);
      rd_case(16'h0000, aw[0]);
    end

    // R4 R5 write sweep
    for (int aw = 0; aw < 2; aw++) begin
      wr_reg(8'hFF, aw ? 16'h0080 : 16'h0000);
      for (int v = 0; v < 16'h1900; v += 16'h0F6) wr_case(16'(v), aw[0], 16'(v * 3 + 16'h1234));
      wr_case(16'h0BFE, aw[0], 16'hBEEF);
      wr_case(16'h0BFF, aw[0], 16'h0102);
      wr_case(16'h0C00, aw[0], 16'h8001);
      wr_case(16'h17FE, aw[0], 16'h55AA);
      wr_case(16'hFFFE, aw[0], 16'hF00D);
    end

    // R7 auto-wrap turn-on
    wr_reg(8'hFF, 16'h0000);
    set_ptr(1'b1, 16'h1234);
    wr_reg(8'hFF, 16'h0080);
    get_ptr(1'b1, p); check("R7 turn-on forces high byte", p, 16'h0C34);
    set_ptr(1'b1, 16'h2255);
    wr_reg(8'hFF, 16'h0083);
    get_ptr(1'b1, p); check("R7 already on keeps pointer", p, 16'h2255);
    wr_reg(8'hFF, 16'h0000);
    get_ptr(1'b1, p); check("R7 turn-off keeps pointer", p, 16'h2255);

    // R9 unmapped indexes
    set_ptr(1'b1, 16'h1357);
    set_ptr(1'b0, 16'h0246);
    wr_reg(8'hFF, 16'h0005);
    begin
      int n0;
      n0 = wlog_n;
      wr_reg(8'h10, 16'hFFFF);
      wr_reg(8'hF0, 16'hFFFF);
      wr_reg(8'hF2, 16'hFFFF);
      check("R9 no memory write", 16'(wlog_n - n0), 16'd0);
    end
    rd_reg(8'h10, q); check("R9 unmapped reads zero", q, 16'h0000);
    rd_reg(8'hF8, q); check("R9 write command reads zero", q, 16'h0000);
    rd_reg(8'hF6, q); check("R9 stay command reads zero", q, 16'h0000);
    get_ptr(1'b1, p); check("R9 read pointer untouched", p, 16'h1357);
    get_ptr(1'b0, p); check("R9 write pointer untouched", p, 16'h0246);
    rd_reg(8'hFF, m); check("R9 mask untouched", m, 16'h0005);

    // R10 stalled grant
    set_ptr(1'b1, 16'h0100);
    xfer(1'b0, 1'b1, 16'h00F2, q);
    @(negedge clk);
    mem_gnt = 1'b0;
    bus_valid = 1'b1; bus_write = 1'b0; bus_data_sel = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #0.5 check("R10 ready low while not granted", {15'h0, bus_ready}, 16'h0000);
      @(negedge clk);
    end
    mem_gnt = 1'b1;
    #0.5 check("R10 ready on grant", {15'h0, bus_ready}, 16'h0001);
    check("R10 R2 granted data", bus_rdata, word_at(16'h0100));
    @(posedge clk); #0.5 bus_valid = 1'b0;
    get_ptr(1'b1, p); check("R10 single advance", p, 16'h0102);

    finish_up();
  end
endmodule